// File: doc/BRIEF.md
# Pen-Interrupt Scan Trigger Controller

This block converts a level-sensitive pen-down request from a resistive touch front end into a paced series of one-cycle scan-start pulses. While the pen stays down, each finished scan is followed by a wait, so consecutive scans begin one scan interval apart. The measured scan time is taken off that wait. The request input is masked from the moment a scan is launched until its pacing wait has ended. This prevents a held pen from starting back-to-back scans.

Once the pen lifts, the request no longer fires. A one-shot timer, armed after every interrupt-started scan, then launches one more scan so that the release shows up in the sampled data. After that trailing scan the timer is not re-armed, and the block sits idle with the request unmasked until the pen touches again. A fresh pen-down cancels a pending one-shot. Clearing the trigger enable masks the request and drops any pending one-shot.

A parameterised divider derives a microsecond tick from the system clock, and every wait is counted in those ticks. The pen level passes through a two-flop synchroniser before the control logic sees it.

Top module: `pen_scan_trigger`

## Requirements
- R1: After reset, `scan_start` is 0, `irq_mask` is 1 and `slow_warn` is 0.
- R2: With `trig_en` high and `irq_mask` low, a high `pen_lvl` (active high) gives exactly one `scan_start` pulse no more than 4 clock cycles after it rises. `irq_mask` is 1 in the cycle of that pulse.
- R3: While the pen is held and `scan_us` is below `INTERVAL_US`, the next start follows `scan_done` after `INTERVAL_US - scan_us` ticks of `CLK_PER_US` cycles, plus a few cycles.
- R4: When `scan_us` is at least `INTERVAL_US`, the pacing wait is skipped and the next start follows `scan_done` within 4 cycles.
- R5: After the pen is released, exactly one trailing start follows the last pacing wait, after ceil(`INTERVAL_US`/`US_PER_MS`)·`US_PER_MS` ticks. No further start follows, and `irq_mask` returns to 0.
- R6: A pen-down while the one-shot is pending starts a scan through the request path within 4 cycles. It cancels the one-shot.
- R7: With `trig_en` low, `irq_mask` is 1, no start is issued, and a pending one-shot is dropped. Raising `trig_en` unmasks the request.
- R8: `slow_warn` is 1 exactly when `scan_us > INTERVAL_US`, one cycle after `scan_us` changes.
- R9: A `scan_done` pulse while no scan is in progress is ignored. It causes no start and leaves `irq_mask` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pen_lvl | input | 1 | Pen-down request level, active high, asynchronous |
| trig_en | input | 1 | Trigger enable |
| scan_done | input | 1 | One-cycle pulse when the scan engine finishes |
| scan_us | input | SCAN_W | Duration of one scan in microsecond ticks |
| scan_start | output | 1 | One-cycle pulse that starts a scan |
| irq_mask | output | 1 | High while the pen request is masked |
| slow_warn | output | 1 | High when the interval is shorter than the scan time |

## Verification
A request start is due two synchroniser cycles plus one register cycle after `pen_lvl` rises. The bench therefore allows four cycles before it declares a start missing. The pacing and one-shot waits depend on the phase of the free-running tick, so each expected start-to-start gap is computed from the tick count times `CLK_PER_US`. The bench accepts one tick of phase slack plus the fixed register cycles and does not demand an exact edge. All outputs are sampled on the falling edge. Quiet periods, in which no start may occur, are watched for several times the longest wait before the bench concludes that no start will follow.

// File: rtl/pst_pkg.sv
package pst_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_PACE = 2'd2
   } pst_state_e;
endpackage

// File: rtl/pst_sync2.sv
module pst_sync2 #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= RST_VAL;
         q_sync <= RST_VAL;
      end else begin
         meta_q <= d_async;
         q_sync <= meta_q;
      end
   end
endmodule

// File: rtl/pst_tick_div.sv
module pst_tick_div #(
   parameter int CLK_PER_US = 125
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("pst_tick_div: CLK_PER_US must be at least 1");
      end

      if (CLK_PER_US == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);
         logic [CW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                   div_q <= div_q + 1'b1;
         end

         assign tick = (div_q == LAST);

         AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick); // R3
      end
   endgenerate
endmodule

// File: rtl/pst_dn_timer.sv
module pst_dn_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         cancel,
   output logic         busy,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("pst_dn_timer: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (cancel) begin
            cnt_q <= '0;
         end else if (load) begin
            cnt_q <= load_val;
         end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == W'(1)) expire <= 1'b1;
         end
      end
   end

   assign busy = (cnt_q != '0);

   AST_EXPIRE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> $past(busy)); // R5
endmodule

// File: rtl/pen_scan_trigger.sv
module pen_scan_trigger #(
   parameter int CLK_PER_US  = 125,
   parameter int INTERVAL_US = 10000,
   parameter int US_PER_MS   = 1000,
   parameter int SCAN_W      = 16,
   parameter int EXTRA_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pen_lvl,
   input  logic              trig_en,
   input  logic              scan_done,
   input  logic [SCAN_W-1:0] scan_us,
   output logic              scan_start,
   output logic              irq_mask,
   output logic              slow_warn
);
   import pst_pkg::*;

   localparam int ONESHOT_US = ((INTERVAL_US + US_PER_MS - 1) / US_PER_MS) * US_PER_MS;
   localparam int TW         = $clog2(ONESHOT_US + 1);
   localparam logic [EXTRA_W-1:0] EXTRA_MAX = '1;

   generate
      if (INTERVAL_US < 1 || US_PER_MS < 1) begin : g_bad_time
         $error("pen_scan_trigger: INTERVAL_US and US_PER_MS must be positive");
      end
      if (SCAN_W < 1 || SCAN_W > 31) begin : g_bad_scan_w
         $error("pen_scan_trigger: SCAN_W must lie in 1..31");
      end
      if (EXTRA_W < 1) begin : g_bad_extra
         $error("pen_scan_trigger: EXTRA_W must be at least 1");
      end
   endgenerate

   logic          tick;
   logic          pen_s;
   pst_state_e    st_q;
   logic          en_q;
   logic [EXTRA_W-1:0] extra_q;
   logic          irq_fire;
   logic          skip_pace;
   logic          finish;
   logic          arm_os;
   logic          pace_load;
   logic [TW-1:0] pace_val;
   logic [31:0]   scan_ext;
   logic          pace_busy, pace_exp;
   logic          os_busy, os_exp;
   logic          os_cancel;

   pst_tick_div #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   pst_sync2 #(.RST_VAL(1'b0)) u_pen_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pen_lvl), .q_sync(pen_s)
   );

   assign scan_ext  = {{(32-SCAN_W){1'b0}}, scan_us};
   assign skip_pace = (scan_ext >= 32'(INTERVAL_US));
   assign pace_val  = TW'(32'(INTERVAL_US) - scan_ext);

   assign irq_fire  = trig_en && (st_q == ST_IDLE) && !irq_mask && pen_s;
   assign finish    = trig_en && (((st_q == ST_SCAN) && scan_done && skip_pace) ||
                                  ((st_q == ST_PACE) && pace_exp));
   assign arm_os    = finish && (extra_q == '0);
   assign pace_load = trig_en && (st_q == ST_SCAN) && scan_done && !skip_pace;
   assign os_cancel = irq_fire || !trig_en;

   pst_dn_timer #(.W(TW)) u_pace (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(pace_load), .load_val(pace_val), .cancel(!trig_en),
      .busy(pace_busy), .expire(pace_exp)
   );

   pst_dn_timer #(.W(TW)) u_oneshot (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(arm_os), .load_val(TW'(ONESHOT_US)), .cancel(os_cancel),
      .busy(os_busy), .expire(os_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         en_q       <= 1'b0;
         irq_mask   <= 1'b1;
         extra_q    <= '0;
         scan_start <= 1'b0;
         slow_warn  <= 1'b0;
      end else begin
         scan_start <= 1'b0;
         en_q       <= trig_en;
         slow_warn  <= (scan_ext > 32'(INTERVAL_US));
         if (!trig_en) begin
            irq_mask <= 1'b1;
            st_q     <= ST_IDLE;
         end else begin
            if (!en_q) irq_mask <= 1'b0;
            case (st_q)
               ST_IDLE: begin
                  if (irq_fire) begin
                     extra_q    <= '0;
                     irq_mask   <= 1'b1;
                     scan_start <= 1'b1;
                     st_q       <= ST_SCAN;
                  end else if (os_exp) begin
                     if (extra_q != EXTRA_MAX) extra_q <= extra_q + 1'b1;
                     irq_mask   <= 1'b1;
                     scan_start <= 1'b1;
                     st_q       <= ST_SCAN;
                  end
               end
               ST_SCAN: begin
                  if (scan_done) begin
                     if (skip_pace) begin
                        irq_mask <= 1'b0;
                        st_q     <= ST_IDLE;
                     end else begin
                        st_q <= ST_PACE;
                     end
                  end
               end
               ST_PACE: begin
                  if (pace_exp) begin
                     irq_mask <= 1'b0;
                     st_q     <= ST_IDLE;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_START_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      scan_start |-> irq_mask); // R2
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_start |=> !scan_start); // R2
   AST_OFF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_en |=> irq_mask); // R7
   AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_en |=> !scan_start); // R7
   AST_PACE_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (pace_busy && trig_en) |-> irq_mask); // R3
   AST_ONESHOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (os_busy && trig_en) |-> (st_q == ST_IDLE)); // R5
endmodule

// File: tb/pen_scan_trigger_tb.sv
module pen_scan_trigger_tb;
   localparam int P     = 4;
   localparam int IV    = 20;
   localparam int UPM   = 8;
   localparam int OS    = ((IV + UPM - 1) / UPM) * UPM;
   localparam int SCYC  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pen_lvl = 1'b0;
   logic trig_en = 1'b0;
   logic scan_done = 1'b0;
   logic [15:0] scan_us = 16'd5;
   logic scan_start, irq_mask, slow_warn;

   int n_run = 0, n_fail = 0;
   int cyc = 0;
   int n_starts = 0;
   int last_start = 0, prev_start = 0;
   int busy_cnt = 0;
   logic poke = 1'b0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   pen_scan_trigger #(
      .CLK_PER_US(P), .INTERVAL_US(IV), .US_PER_MS(UPM), .SCAN_W(16), .EXTRA_W(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pen_lvl(pen_lvl), .trig_en(trig_en),
      .scan_done(scan_done), .scan_us(scan_us),
      .scan_start(scan_start), .irq_mask(irq_mask), .slow_warn(slow_warn)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // scan engine model and start monitor
   always @(negedge clk) begin
      scan_done <= 1'b0;
      if (scan_start) begin
         n_starts   <= n_starts + 1;
         prev_start <= last_start;
         last_start <= cyc;
         busy_cnt   <= SCYC;
      end else if (busy_cnt > 0) begin
         busy_cnt <= busy_cnt - 1;
         if (busy_cnt == 1) scan_done <= 1'b1;
      end
      if (poke) scan_done <= 1'b1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_start(input int limit, output bit got);
      int base = n_starts;
      got = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         #1;
         if (n_starts != base) begin got = 1'b1; break; end
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
   end

   initial begin
      bit got;
      int gap, d, lo, hi, base;
      repeat (3) @(negedge clk);
      check(scan_start == 1'b0 && irq_mask == 1'b1 && slow_warn == 1'b0, "R1",
            {scan_start, irq_mask, slow_warn}, 3'b010);
      rst_n = 1'b1;
      @(negedge clk);
      trig_en = 1'b1;
      repeat (3) @(negedge clk);
      check(irq_mask == 1'b0, "R7 unmask on enable", irq_mask, 0);

      // R2: request start
      pen_lvl = 1'b1;
      wait_start(4, got);
      check(got, "R2 start latency", got, 1);
      check(irq_mask == 1'b1, "R2 masked at start", irq_mask, 1);

      // R3/R4/R8 sweep over scan time
      for (int su = 0; su <= 28; su += 4) begin
         scan_us = 16'(su);
         @(negedge clk); #1;
         check(slow_warn == (su > IV), "R8 warn flag", slow_warn, (su > IV));
         d = (su < IV) ? IV - su : 0;
         wait_start(400, got);
         for (int k = 0; k < 2; k++) begin
            wait_start(400, got);
            gap = last_start - prev_start;
            lo = SCYC + ((d > 0) ? (d - 1) * P : 0);
            hi = SCYC + d * P + 6;
            if (d > 0) check(got && gap >= lo && gap <= hi, "R3 paced gap", gap, SCYC + d * P);
            else       check(got && gap >= lo && gap <= hi, "R4 skipped pace", gap, SCYC);
         end
      end

      // R5: release gives one trailing scan
      scan_us = 16'd5; d = IV - 5;
      wait_start(400, got);
      wait_start(400, got);
      pen_lvl = 1'b0;
      wait_start(SCYC + (d + OS) * P + 20, got);
      gap = last_start - prev_start;
      check(got && gap >= SCYC + (d + OS - 2) * P && gap <= SCYC + (d + OS) * P + 8,
            "R5 trailing gap", gap, SCYC + (d + OS) * P);
      base = n_starts;
      repeat (600) @(negedge clk);
      check(n_starts == base, "R5 idle after trailing", n_starts - base, 0);
      check(irq_mask == 1'b0, "R5 unmasked idle", irq_mask, 0);

      // R9: stray done ignored
      poke = 1'b1; @(negedge clk); poke = 1'b0;
      repeat (100) @(negedge clk);
      check(n_starts == base && irq_mask == 1'b0, "R9 stray done", n_starts - base, 0);

      // R6: re-press during one-shot wait
      pen_lvl = 1'b1;
      wait_start(4, got);
      check(got, "R6 press start", got, 1);
      pen_lvl = 1'b0;
      repeat (SCYC + d * P + 40) @(negedge clk);
      pen_lvl = 1'b1;
      wait_start(4, got);
      check(got, "R6 re-press start", got, 1);
      gap = last_start - prev_start;
      check(gap < SCYC + (d + OS - 2) * P, "R6 not timer start", gap, SCYC + d * P + 40);
      pen_lvl = 1'b0;
      wait_start(SCYC + (d + OS) * P + 20, got);
      check(got, "R6 trailing after re-press", got, 1);
      base = n_starts;
      repeat (600) @(negedge clk);
      check(n_starts == base, "R6 quiet", n_starts - base, 0);

      // R7: disabled ignores pen; disabling drops pending one-shot
      trig_en = 1'b0;
      pen_lvl = 1'b1;
      repeat (200) @(negedge clk);
      check(n_starts == base && irq_mask == 1'b1, "R7 disabled", n_starts - base, 0);
      trig_en = 1'b1;
      wait_start(8, got);
      check(got, "R7 start after enable", got, 1);
      pen_lvl = 1'b0;
      repeat (SCYC + d * P + 40) @(negedge clk);
      trig_en = 1'b0;
      base = n_starts;
      repeat (600) @(negedge clk);
      check(n_starts == base, "R7 one-shot dropped", n_starts - base, 0);
      check(irq_mask == 1'b1, "R7 masked when off", irq_mask, 1);

      finish_run();
   end
endmodule